// File: doc/BRIEF.md
# Multi-Queue Almost-Full Flag Tracker

This block follows the fill level of four independent queues that share one write port and one read port. It drives a single active-low almost-full indication for whichever queue the write port currently points at. The write side picks a queue by presenting an address with an address-enable strobe. Each accepted write adds one word to the chosen queue. The read side removes words through a per-queue decrement strobe. Both sides run on one clock. The block stores no data and produces no read-side flags.

The write address holds a device field above a queue field. Several instances can therefore share one flag line. Only the instance whose identifier matches the device field drives the flag. The other instances release the line, which is modelled here as an output-enable that travels beside the flag value. The flag follows the selected queue through a fixed two-cycle write-side pipeline. A read that drains the selected queue below the threshold uses a one-cycle release path instead. The threshold offset sits in a register with a reset value. That register can be reloaded only on a cycle with no queue activity.

Top module: `mq_afull_tracker`

## Requirements
- R1: Each queue keeps its own word count. An accepted write adds one to the selected queue only. Bit q of `rd_dec_i` (q = 0..3) takes one word from queue q only, whichever queue is selected.
- R2: On a clock edge where `wr_aden_i` is 1, the queue index `wr_addr_i[1:0]` and the device field `wr_addr_i[3:2]` are captured. No word is written on that edge, even if `wr_en_i` is 1.
- R3: The flag `afull_n_o` is active low. With depth D and offset m, the selected queue counts as almost full at D-m words or more. It is not almost full at D-(m+1) words or fewer.
- R4: After the write edge that takes the selected queue to the threshold, `afull_n_o` goes low at the second following rising edge.
- R5: After the edge that selects a different queue, `afull_n_o` shows the new queue's state from the second following rising edge on. It returns high at that point if the new queue is not almost full.
- R6: A read of the selected queue that takes it below the threshold sets `afull_n_o` high at the next rising edge.
- R7: `afull_oe_o` is 1 only while the captured device field equals the instance identifier (1 by default). It changes on the selecting edge itself.
- R8: A write to a queue holding D words and a read from an empty queue are both ignored. The count saturates at D and at 0.
- R9: A load of the offset takes effect only on a cycle where `wr_en_i`, `wr_aden_i` and every bit of `rd_dec_i` are 0. On any other cycle the load is ignored.
- R10: After reset, every count is 0, queue 0 is selected, the instance is not selected, `afull_n_o` is 1, `afull_oe_o` is 0, and m holds its reset value (2 by default, with D = 16).
- R11: While another device is selected, writes change no count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset |
| wr_addr_i | input | 4 | Device field [3:2], queue field [1:0] |
| wr_aden_i | input | 1 | Address-enable strobe that captures `wr_addr_i` |
| wr_en_i | input | 1 | Write one word into the selected queue |
| rd_dec_i | input | 4 | Per-queue read strobe, bit q for queue q |
| offs_load_i | input | 1 | Load request for the threshold offset |
| offs_i | input | 5 | New threshold offset m |
| afull_n_o | output | 1 | Active-low almost-full flag of the selected queue |
| afull_oe_o | output | 1 | Flag drive enable (0 means released) |

## Verification
Assertions check the following on every cycle:
- Each counter moves by at most one word and holds at its saturation limits.
- A selecting edge and a foreign selection leave all counts unchanged.
- A busy-cycle load leaves the offset unchanged.
- The output-enable follows the captured device field.
- Every fall of the flag is backed by the threshold comparison two cycles earlier.
- Every rise of the flag is backed by a not-almost-full comparison one or two cycles earlier.

Some behaviour can only be shown by the bench's scenarios. These cover the exact cycles at which the flag changes after a crossing write, a queue switch and a draining read, and the fact that writes while another device is selected never reach any queue. They also show that extra writes to a full queue, or reads of an empty one, leave no trace in later flag values.

// File: rtl/mqf_pkg.sv
package mqf_pkg;

  // Almost-full test: count has reached depth minus offset.
  function automatic logic at_or_above(input int unsigned cnt,
                                       input int unsigned offs,
                                       input int unsigned depth);
    return (cnt + offs) >= depth;
  endfunction

endpackage

// File: rtl/mqf_qcount.sv
module mqf_qcount #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_req,
  input  logic             dec_req,
  output logic [CNT_W-1:0] cnt,
  output logic             dec_acc
);

  logic inc_acc;

  assign inc_acc = inc_req && (cnt != CNT_W'(DEPTH));
  assign dec_acc = dec_req && (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (inc_acc && !dec_acc) begin
      cnt <= cnt + 1'b1;
    end else if (dec_acc && !inc_acc) begin
      cnt <= cnt - 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_W'(DEPTH) && !dec_req) |=> (cnt == CNT_W'(DEPTH))); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && !inc_req) |=> (cnt == '0)); // R8
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH)); // R8
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    ##1 ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1))); // R1

endmodule

// File: rtl/mqf_wsel.sv
module mqf_wsel #(
  parameter int NUM_Q  = 4,
  parameter int DEV_W  = 2,
  parameter int DEV_ID = 1,
  localparam int QW = $clog2(NUM_Q),
  localparam int AW = DEV_W + QW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          aden,
  input  logic [AW-1:0] addr,
  output logic [QW-1:0] sel_q,
  output logic          own_q
);

  logic [DEV_W-1:0] dev_field;
  logic [QW-1:0]    q_field;

  assign dev_field = addr[AW-1:QW];
  assign q_field   = addr[QW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      own_q <= 1'b0;
    end else if (aden) begin
      sel_q <= q_field;
      own_q <= (dev_field == DEV_W'(DEV_ID));
    end
  end

  AST_OE_DEVICE: assert property (@(posedge clk) disable iff (rst)
    aden |=> (own_q == ($past(addr[AW-1:QW]) == DEV_W'(DEV_ID)))); // R7
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !aden |=> ($stable(sel_q) && $stable(own_q))); // R2

endmodule

// File: rtl/mqf_offs_reg.sv
module mqf_offs_reg #(
  parameter int CNT_W  = 5,
  parameter int M_INIT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             busy,
  input  logic [CNT_W-1:0] val,
  output logic [CNT_W-1:0] offs_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      offs_q <= CNT_W'(M_INIT);
    end else if (load && !busy) begin
      offs_q <= val;
    end
  end

  AST_OFFS_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (load && busy) |=> $stable(offs_q)); // R9
  AST_OFFS_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(offs_q)); // R9

endmodule

// File: rtl/mqf_flag_pipe.sv
module mqf_flag_pipe (
  input  logic clk,
  input  logic rst,
  input  logic thr_now,
  input  logic rd_sel,
  output logic flag_n
);

  logic thr_d1;
  logic rd_d1;
  logic fast_rel;

  // Release early when the previous edge took a word from the selected queue
  // and the queue now sits below the threshold.
  assign fast_rel = rd_d1 && !thr_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_d1 <= 1'b0;
      rd_d1  <= 1'b0;
      flag_n <= 1'b1;
    end else begin
      thr_d1 <= thr_now;
      rd_d1  <= rd_sel;
      flag_n <= fast_rel ? 1'b1 : !thr_d1;
    end
  end

  AST_FALL_LATENCY: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_n) |-> $past(thr_now, 2)); // R4
  AST_RISE_PATH: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_n) |-> (!$past(thr_now, 1) || !$past(thr_now, 2))); // R6

endmodule

// File: rtl/mq_afull_tracker.sv
module mq_afull_tracker #(
  parameter int NUM_Q  = 4,
  parameter int DEPTH  = 16,
  parameter int DEV_W  = 2,
  parameter int DEV_ID = 1,
  parameter int M_INIT = 2,
  localparam int QW    = $clog2(NUM_Q),
  localparam int AW    = DEV_W + QW,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic             wr_aden_i,
  input  logic             wr_en_i,
  input  logic [NUM_Q-1:0] rd_dec_i,
  input  logic             offs_load_i,
  input  logic [CNT_W-1:0] offs_i,
  output logic             afull_n_o,
  output logic             afull_oe_o
);

  logic [QW-1:0]                 sel_q;
  logic                          own_q;
  logic [CNT_W-1:0]              offs_q;
  logic [NUM_Q-1:0][CNT_W-1:0]   cnt;
  logic [NUM_Q-1:0]              inc_req;
  logic [NUM_Q-1:0]              dec_acc;
  logic                          wr_ok;
  logic                          busy;
  logic                          thr_now;
  logic                          rd_sel;

  mqf_wsel #(
    .NUM_Q (NUM_Q),
    .DEV_W (DEV_W),
    .DEV_ID(DEV_ID)
  ) u_wsel (
    .clk  (clk),
    .rst  (rst),
    .aden (wr_aden_i),
    .addr (wr_addr_i),
    .sel_q(sel_q),
    .own_q(own_q)
  );

  assign busy = wr_en_i || wr_aden_i || (|rd_dec_i);

  mqf_offs_reg #(
    .CNT_W (CNT_W),
    .M_INIT(M_INIT)
  ) u_offs (
    .clk   (clk),
    .rst   (rst),
    .load  (offs_load_i),
    .busy  (busy),
    .val   (offs_i),
    .offs_q(offs_q)
  );

  // Writes go nowhere on a selecting edge or while another device is selected.
  assign wr_ok = wr_en_i && !wr_aden_i && own_q;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    assign inc_req[q] = wr_ok && (sel_q == QW'(q));

    mqf_qcount #(
      .DEPTH(DEPTH)
    ) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .inc_req(inc_req[q]),
      .dec_req(rd_dec_i[q]),
      .cnt    (cnt[q]),
      .dec_acc(dec_acc[q])
    );
  end

  assign thr_now = mqf_pkg::at_or_above(32'(cnt[sel_q]), 32'(offs_q), 32'(DEPTH));
  assign rd_sel  = dec_acc[sel_q] && !wr_aden_i;

  mqf_flag_pipe u_flag (
    .clk    (clk),
    .rst    (rst),
    .thr_now(thr_now),
    .rd_sel (rd_sel),
    .flag_n (afull_n_o)
  );

  assign afull_oe_o = own_q;

  AST_SWITCH_NOWRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_aden_i && rd_dec_i == '0) |=> $stable(cnt)); // R2
  AST_FOREIGN_NOWRITE: assert property (@(posedge clk) disable iff (rst)
    (!own_q && !wr_aden_i && rd_dec_i == '0) |=> $stable(cnt)); // R11
  AST_ONE_QUEUE_WRITE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(inc_req)); // R1

endmodule

// File: tb/mq_afull_tracker_tb.sv
`timescale 1ns/1ps
module mq_afull_tracker_tb;

  localparam int D = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] wr_addr = '0;
  logic       wr_aden = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] rd_dec = '0;
  logic       offs_load = 1'b0;
  logic [4:0] offs = '0;
  logic       afull_n;
  logic       afull_oe;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mq_afull_tracker u_dut (
    .clk        (clk),
    .rst        (rst),
    .wr_addr_i  (wr_addr),
    .wr_aden_i  (wr_aden),
    .wr_en_i    (wr_en),
    .rd_dec_i   (rd_dec),
    .offs_load_i(offs_load),
    .offs_i     (offs),
    .afull_n_o  (afull_n),
    .afull_oe_o (afull_oe)
  );

  // Behavioural reference model
  int mc[4];
  int msel = 0, mown = 0, mm = 2, mthr = 0, mrd = 0, mflag = 1;

  always @(posedge clk) begin
    if (rst) begin
      foreach (mc[i]) mc[i] = 0;
      msel = 0; mown = 0; mm = 2; mthr = 0; mrd = 0; mflag = 1;
    end else begin
      int thr_n, busy, rds, nf;
      thr_n = (mc[msel] + mm >= D) ? 1 : 0;
      busy  = (wr_en || wr_aden || rd_dec != 0) ? 1 : 0;
      rds   = (rd_dec[msel] && mc[msel] > 0 && !wr_aden) ? 1 : 0;
      nf    = (mrd && !thr_n) ? 1 : (mthr ? 0 : 1);
      mthr  = thr_n;
      mrd   = rds;
      mflag = nf;
      for (int q = 0; q < 4; q++) begin
        int w, r;
        w = (wr_en && !wr_aden && mown && msel == q && mc[q] < D) ? 1 : 0;
        r = (rd_dec[q] && mc[q] > 0) ? 1 : 0;
        mc[q] = mc[q] + w - r;
      end
      if (wr_aden) begin
        msel = int'(wr_addr[1:0]);
        mown = (wr_addr[3:2] == 2'd1) ? 1 : 0;
      end
      if (offs_load && !busy) mm = int'(offs);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R3 R4 R5 R6 model flag", int'(afull_n), mflag);
      chk("R7 model oe", int'(afull_oe), mown);
    end
  end

  task automatic cyc(input logic we, input logic ad, input logic [3:0] a,
                     input logic [3:0] dec, input logic ld, input logic [4:0] ov);
    wr_en = we; wr_aden = ad; wr_addr = a; rd_dec = dec; offs_load = ld; offs = ov;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) cyc(0, 0, 4'h0, 4'h0, 0, 5'd0);
  endtask

  task automatic sel(input logic [1:0] dev, input logic [1:0] q, input logic we);
    cyc(we, 1, {dev, q}, 4'h0, 0, 5'd0);
  endtask

  task automatic wr(input int n);
    repeat (n) cyc(1, 0, 4'h0, 4'h0, 0, 5'd0);
  endtask

  task automatic rd(input logic [3:0] dec, input int n);
    repeat (n) cyc(0, 0, 4'h0, dec, 0, 5'd0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    idle(4);
    rst = 1'b0;
    idle(1);
    chk("R10 reset flag", int'(afull_n), 1);
    chk("R10 reset oe", int'(afull_oe), 0);

    // Select device 1 queue 2 with a write on the same edge
    sel(2'd1, 2'd2, 1);
    chk("R7 oe on selecting edge", int'(afull_oe), 1);
    wr(13);
    idle(3);
    chk("R2 R3 select-cycle write dropped, 13 words high", int'(afull_n), 1);
    wr(1);
    chk("R4 edge 0 after crossing write", int'(afull_n), 1);
    idle(1);
    chk("R4 edge 1 after crossing write", int'(afull_n), 1);
    idle(1);
    chk("R4 edge 2 after crossing write", int'(afull_n), 0);

    // Switch to empty queue 0
    sel(2'd1, 2'd0, 0);
    chk("R5 edge 0 after switch", int'(afull_n), 0);
    idle(1);
    chk("R5 edge 1 after switch", int'(afull_n), 0);
    idle(1);
    chk("R5 edge 2 after switch", int'(afull_n), 1);
    sel(2'd1, 2'd2, 0);
    idle(2);
    chk("R5 back to queue 2", int'(afull_n), 0);

    // Read releases on the next edge
    rd(4'b0100, 1);
    chk("R6 edge 0 after read", int'(afull_n), 0);
    idle(1);
    chk("R6 edge 1 after read", int'(afull_n), 1);

    // Foreign device selection
    sel(2'd2, 2'd1, 0);
    chk("R7 foreign device oe", int'(afull_oe), 0);
    wr(16);
    sel(2'd1, 2'd1, 0);
    idle(2);
    chk("R11 queue 1 untouched", int'(afull_n), 1);
    chk("R7 own device oe", int'(afull_oe), 1);
    sel(2'd1, 2'd2, 0);
    idle(2);
    chk("R11 queue 2 untouched", int'(afull_n), 1);

    // Saturation on queue 3
    sel(2'd1, 2'd3, 0);
    wr(19);
    idle(2);
    chk("R8 full queue flag", int'(afull_n), 0);
    rd(4'b1000, 3);
    idle(2);
    chk("R8 extra writes ignored", int'(afull_n), 1);
    rd(4'b1000, 20);
    wr(13);
    idle(3);
    chk("R8 extra reads ignored, 13 words", int'(afull_n), 1);
    wr(1);
    idle(2);
    chk("R8 14 words after empty reads", int'(afull_n), 0);

    // Read strobe of a non-selected queue
    rd(4'b0100, 1);
    idle(2);
    chk("R1 other queue read leaves flag", int'(afull_n), 0);

    // Offset loads
    cyc(0, 0, 4'h0, 4'b0001, 1, 5'd0);
    idle(3);
    chk("R9 busy load ignored", int'(afull_n), 0);
    cyc(0, 0, 4'h0, 4'h0, 1, 5'd0);
    idle(2);
    chk("R9 idle load applied", int'(afull_n), 1);
    wr(2);
    idle(2);
    chk("R3 offset 0 threshold at depth", int'(afull_n), 0);

    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule